// File: doc/BRIEF.md
# Lazy-Flag Arithmetic Logic Unit

This unit performs the integer arithmetic and bitwise work of a 16-bit CISC core. Each cycle it can accept one operation together with its destination and source operands, an operation code and a width select (byte or word). On the next clock edge it presents the result, a one-cycle write-enable that tells the register file or memory stage to store that result, and a six-bit status flag register.

Addition and subtraction, with or without the incoming carry, share one two-stage carry chain. The first stage combines the operands. The second stage folds in the old carry flag. The outgoing carry is the OR of the carries (or borrows) of the two stages. Signed overflow is derived from the sign bits of the destination, the source and the result, tested under a sign mask that follows the selected width. The bitwise operations, the increment and decrement operations and the compare-only operations each apply their own flag rules. The flag register is the only state carried from one operation to the next.

Top module: `lf_alu`

## Requirements
- R1: While reset is asserted and after it is released, before any operation, `res_out`, `res_we` and `flags_out` are all zero. Flag bit positions are CF=0, PF=1, AF=2, ZF=3, SF=4, OF=5.
- R2: Opcode 0 adds and opcode 2 subtracts (destination minus source). The result is truncated to the selected width. CF is set on a carry out of, or a borrow into, the top bit of that width.
- R3: Opcode 1 adds source and old CF to destination. Opcode 3 subtracts source and then old CF from destination. CF out is the OR of the two stages' carries or borrows.
- R4: For opcodes 0 and 1, OF is set only when, at the sign bit, both operands share a sign and the result's sign differs from the original destination's sign.
- R5: For opcodes 2, 3 and 7, OF is set only when the operands' sign bits differ and the result's sign differs from the original destination's sign.
- R6: Opcodes 4 (AND), 5 (OR), 6 (XOR) and 8 (TEST, an AND) clear CF, OF and AF.
- R7: Opcode 9 adds one and opcode 10 subtracts one. Both keep CF at its prior value. OF is set on increment when the result equals the sign mask, and on decrement when the result equals the sign mask minus one.
- R8: ZF is set when the width-truncated result is zero. SF copies the result's top bit at the selected width. PF is set when the low 8 result bits hold an even count of ones. For arithmetic, increment and decrement, AF is bit 4 of destination XOR source XOR result, where the source is 1 for increment and decrement.
- R9: Opcode 7 (compare, a subtract) and opcode 8 update the flags but never assert `res_we`, and `res_out` keeps its previous value.
- R10: With `op_word` low, operand bits 15:8 are ignored, the sign bit is bit 7, and result bits 15:8 are zero. With `op_word` high, the sign bit is bit 15.
- R11: A cycle with `op_valid` low, or with an opcode from 11 to 15, changes neither the flags nor `res_out` and leaves `res_we` low.
- R12: Results and flags appear on the clock edge that samples `op_valid`. `res_we` is high for exactly that one following cycle per writing operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_valid | input | 1 | Operation strobe for this cycle |
| op_code | input | 4 | Operation select (0..10 defined) |
| op_word | input | 1 | 1 = 16-bit width, 0 = 8-bit width |
| dst_in | input | 16 | Destination operand |
| src_in | input | 16 | Source operand |
| res_out | output | 16 | Registered result of the last writing operation |
| res_we | output | 1 | Result write-enable, one cycle per writing operation |
| flags_out | output | 6 | Flag register {OF,SF,ZF,AF,PF,CF} |

## Verification
The assertions check on every cycle the rules that need no arithmetic: bitwise operations clearing CF and OF, increment and decrement keeping CF, compare and test never writing, idle or undefined cycles holding all state, byte results with a clear upper byte, ZF agreeing with every written result, and the two carry stages never both firing. The numeric content can only be shown by the bench's scenarios, compared cycle by cycle with a behavioural model that works in signed integers rather than sign-bit algebra. That content covers sums and differences, overflow at the positive and negative limits, the chained carry of the carry-using operations, parity and the auxiliary carry.

// File: rtl/lf_pkg.sv
package lf_pkg;

  localparam int NFLAGS  = 6;
  localparam int FLAG_CF = 0;
  localparam int FLAG_PF = 1;
  localparam int FLAG_AF = 2;
  localparam int FLAG_ZF = 3;
  localparam int FLAG_SF = 4;
  localparam int FLAG_OF = 5;

  localparam logic [3:0] OP_ADD  = 4'd0;
  localparam logic [3:0] OP_ADC  = 4'd1;
  localparam logic [3:0] OP_SUB  = 4'd2;
  localparam logic [3:0] OP_SBB  = 4'd3;
  localparam logic [3:0] OP_AND  = 4'd4;
  localparam logic [3:0] OP_OR   = 4'd5;
  localparam logic [3:0] OP_XOR  = 4'd6;
  localparam logic [3:0] OP_CMP  = 4'd7;
  localparam logic [3:0] OP_TEST = 4'd8;
  localparam logic [3:0] OP_INC  = 4'd9;
  localparam logic [3:0] OP_DEC  = 4'd10;

  typedef enum logic [2:0] {
    K_ADD   = 3'd0,
    K_SUB   = 3'd1,
    K_LOGIC = 3'd2,
    K_INC   = 3'd3,
    K_DEC   = 3'd4
  } op_kind_e;

endpackage

// File: rtl/lf_carry_chain.sv
module lf_carry_chain #(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic [DATA_W-1:0] a_in,
  input  logic [DATA_W-1:0] b_in,
  input  logic              word_sel,
  input  logic              sub_mode,
  input  logic              carry_in,
  output logic [DATA_W-1:0] sum_out,
  output logic              carry_out
);

  localparam int EXT_W = DATA_W + 1;
  localparam logic [DATA_W-1:0] BYTE_MASK = {{(DATA_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}};

  logic [DATA_W-1:0] width_mask;
  logic [EXT_W-1:0]  stage1;
  logic [EXT_W-1:0]  stage2;
  logic [DATA_W-1:0] stage1_m;
  logic [EXT_W-1:0]  cin_ext;
  logic              c1;
  logic              c2;

  always_comb begin
    width_mask = word_sel ? {DATA_W{1'b1}} : BYTE_MASK;
    cin_ext    = {{(EXT_W-1){1'b0}}, carry_in};
    // first stage: operand against operand
    if (sub_mode) stage1 = {1'b0, a_in} - {1'b0, b_in};
    else          stage1 = {1'b0, a_in} + {1'b0, b_in};
    c1       = word_sel ? stage1[DATA_W] : stage1[BYTE_W];
    stage1_m = stage1[DATA_W-1:0] & width_mask;
    // second stage: fold in incoming carry
    if (sub_mode) stage2 = {1'b0, stage1_m} - cin_ext;
    else          stage2 = {1'b0, stage1_m} + cin_ext;
    c2        = word_sel ? stage2[DATA_W] : stage2[BYTE_W];
    sum_out   = stage2[DATA_W-1:0] & width_mask;
    carry_out = c1 | c2;
  end

  always_comb begin
    AST_SINGLE_CARRY: assert (!(c1 && c2)); // R3
  end

endmodule

// File: rtl/lf_flag_gen.sv
module lf_flag_gen
  import lf_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic [DATA_W-1:0] d_val,
  input  logic [DATA_W-1:0] s_val,
  input  logic [DATA_W-1:0] r_val,
  input  logic              word_sel,
  input  op_kind_e          kind,
  input  logic              chain_carry,
  input  logic              cf_prev,
  output logic [NFLAGS-1:0] flags_new
);

  localparam logic [DATA_W-1:0] SMASK_B = {{(DATA_W-1){1'b0}}, 1'b1} << (BYTE_W-1);
  localparam logic [DATA_W-1:0] SMASK_W = {{(DATA_W-1){1'b0}}, 1'b1} << (DATA_W-1);
  localparam logic [DATA_W-1:0] ONE     = {{(DATA_W-1){1'b0}}, 1'b1};

  logic [DATA_W-1:0] smask;
  logic [DATA_W-1:0] aux_vec;
  logic cf, pf, af, zf, sf, of;

  always_comb begin
    smask   = word_sel ? SMASK_W : SMASK_B;
    aux_vec = d_val ^ s_val ^ r_val;
    zf = (r_val == '0);
    sf = |(r_val & smask);
    pf = ~^r_val[7:0];
    af = aux_vec[4];
    cf = 1'b0;
    of = 1'b0;
    case (kind)
      K_ADD: begin
        cf = chain_carry;
        of = |(smask & ~(d_val ^ s_val) & (d_val ^ r_val));
      end
      K_SUB: begin
        cf = chain_carry;
        of = |(smask & (d_val ^ s_val) & (d_val ^ r_val));
      end
      K_INC: begin
        cf = cf_prev;
        of = (r_val == smask);
      end
      K_DEC: begin
        cf = cf_prev;
        of = (r_val == (smask - ONE));
      end
      default: begin
        cf = 1'b0;
        of = 1'b0;
        af = 1'b0;
      end
    endcase
    flags_new          = '0;
    flags_new[FLAG_CF] = cf;
    flags_new[FLAG_PF] = pf;
    flags_new[FLAG_AF] = af;
    flags_new[FLAG_ZF] = zf;
    flags_new[FLAG_SF] = sf;
    flags_new[FLAG_OF] = of;
  end

endmodule

// File: rtl/lf_alu.sv
module lf_alu
  import lf_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [3:0]        op_code,
  input  logic              op_word,
  input  logic [DATA_W-1:0] dst_in,
  input  logic [DATA_W-1:0] src_in,
  output logic [DATA_W-1:0] res_out,
  output logic              res_we,
  output logic [NFLAGS-1:0] flags_out
);

  localparam logic [DATA_W-1:0] BYTE_MASK = {{(DATA_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}};
  localparam logic [DATA_W-1:0] ONE       = {{(DATA_W-1){1'b0}}, 1'b1};
  localparam int                SYNC_LEN  = 2;

  // reset: asserted asynchronously, released on the clock
  logic [SYNC_LEN-1:0] rst_pipe;
  logic                rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_LEN-2:0], 1'b1};
  end
  assign rst_int_n = rst_pipe[SYNC_LEN-1];

  // operand conditioning and decode
  logic [DATA_W-1:0] width_mask, dst_m, src_m, b_sel, logic_res;
  logic [DATA_W-1:0] chain_sum, alu_res;
  logic              sub_mode, use_cin, writes, known, chain_cout;
  op_kind_e          kind;
  logic [NFLAGS-1:0] flags_new;

  logic [DATA_W-1:0] res_q, res_d;
  logic              we_q, we_d, load_res, load_flags;
  logic [NFLAGS-1:0] flags_q, flags_d;

  always_comb begin
    width_mask = op_word ? {DATA_W{1'b1}} : BYTE_MASK;
    dst_m      = dst_in & width_mask;
    src_m      = src_in & width_mask;
    kind       = K_LOGIC;
    sub_mode   = 1'b0;
    use_cin    = 1'b0;
    writes     = 1'b1;
    known      = 1'b1;
    b_sel      = src_m;
    logic_res  = '0;
    case (op_code)
      OP_ADD:  kind = K_ADD;
      OP_ADC:  begin kind = K_ADD; use_cin = 1'b1; end
      OP_SUB:  begin kind = K_SUB; sub_mode = 1'b1; end
      OP_SBB:  begin kind = K_SUB; sub_mode = 1'b1; use_cin = 1'b1; end
      OP_CMP:  begin kind = K_SUB; sub_mode = 1'b1; writes = 1'b0; end
      OP_AND:  logic_res = dst_m & src_m;
      OP_OR:   logic_res = dst_m | src_m;
      OP_XOR:  logic_res = dst_m ^ src_m;
      OP_TEST: begin logic_res = dst_m & src_m; writes = 1'b0; end
      OP_INC:  begin kind = K_INC; b_sel = ONE; end
      OP_DEC:  begin kind = K_DEC; b_sel = ONE; sub_mode = 1'b1; end
      default: begin known = 1'b0; writes = 1'b0; end
    endcase
  end

  lf_carry_chain #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_chain (
    .a_in      (dst_m),
    .b_in      (b_sel),
    .word_sel  (op_word),
    .sub_mode  (sub_mode),
    .carry_in  (use_cin & flags_q[FLAG_CF]),
    .sum_out   (chain_sum),
    .carry_out (chain_cout)
  );

  assign alu_res = (kind == K_LOGIC) ? logic_res : chain_sum;

  lf_flag_gen #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_flags (
    .d_val       (dst_m),
    .s_val       (b_sel),
    .r_val       (alu_res),
    .word_sel    (op_word),
    .kind        (kind),
    .chain_carry (chain_cout),
    .cf_prev     (flags_q[FLAG_CF]),
    .flags_new   (flags_new)
  );

  // next state
  always_comb begin
    load_res   = op_valid & known & writes;
    load_flags = op_valid & known;
    res_d      = alu_res;
    flags_d    = flags_new;
    we_d       = load_res;
  end

  // registers with explicit enables
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)    res_q <= '0;
    else if (load_res) res_q <= res_d;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)      flags_q <= '0;
    else if (load_flags) flags_q <= flags_d;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) we_q <= 1'b0;
    else            we_q <= we_d;
  end

  assign res_out   = res_q;
  assign res_we    = we_q;
  assign flags_out = flags_q;

  // checks on the registered boundary
  AST_LOGIC_CLEARS_CF_OF: assert property (@(posedge clk) disable iff (!rst_int_n)
    op_valid && (op_code == OP_AND || op_code == OP_OR || op_code == OP_XOR || op_code == OP_TEST)
    |=> !flags_out[FLAG_CF] && !flags_out[FLAG_OF] && !flags_out[FLAG_AF]); // R6

  AST_INCDEC_KEEPS_CF: assert property (@(posedge clk) disable iff (!rst_int_n)
    op_valid && (op_code == OP_INC || op_code == OP_DEC)
    |=> flags_out[FLAG_CF] == $past(flags_out[FLAG_CF])); // R7

  AST_COMPARE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_int_n)
    op_valid && (op_code == OP_CMP || op_code == OP_TEST)
    |=> !res_we && $stable(res_out)); // R9

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_int_n)
    !op_valid || op_code > OP_DEC
    |=> !res_we && $stable(res_out) && $stable(flags_out)); // R11

  AST_BYTE_UPPER_CLEAR: assert property (@(posedge clk) disable iff (!rst_int_n)
    res_we && !$past(op_word) |-> res_out[DATA_W-1:BYTE_W] == '0); // R10

  AST_ZERO_FLAG_MATCH: assert property (@(posedge clk) disable iff (!rst_int_n)
    res_we |-> flags_out[FLAG_ZF] == (res_out == '0)); // R8

  AST_WE_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_int_n)
    res_we |-> $past(op_valid)); // R12

endmodule

// File: tb/sim_lf_alu.sv
module sim_lf_alu;

  logic        clk;
  logic        rst_n;
  logic        op_valid;
  logic [3:0]  op_code;
  logic        op_word;
  logic [15:0] dst_in;
  logic [15:0] src_in;
  logic [15:0] res_out;
  logic        res_we;
  logic [5:0]  flags_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  logic [5:0]  m_flags;
  logic [15:0] m_res;

  lf_alu u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .op_word(op_word), .dst_in(dst_in), .src_in(src_in),
    .res_out(res_out), .res_we(res_we), .flags_out(flags_out)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // one cycle of stimulus; expected state from signed integer arithmetic
  task automatic step(input bit v, input int op, input bit w,
                      input int d_raw, input int s_raw, input string tag);
    int n, mask, d, s, r, full, cin, sd, ss, sr, maxp, minn;
    bit cf, of, af, zf, sf, pf, writes, known, exp_we;
    logic [7:0] low;
    op_valid = v; op_code = op[3:0]; op_word = w;
    dst_in = d_raw[15:0]; src_in = s_raw[15:0];
    n = w ? 16 : 8;
    mask = (1 << n) - 1;
    d = d_raw & mask; s = s_raw & mask;
    maxp = (1 << (n-1)) - 1; minn = -(1 << (n-1));
    sd = (d > maxp) ? d - (1 << n) : d;
    ss = (s > maxp) ? s - (1 << n) : s;
    cf = m_flags[0]; of = 0; af = 0; known = 1; writes = 1; r = 0; cin = 0;
    case (op)
      0, 1: begin
        cin = (op == 1) ? int'(m_flags[0]) : 0;
        full = d + s + cin; r = full & mask; cf = (full > mask);
        sr = sd + ss + cin; of = (sr > maxp) || (sr < minn);
        af = bit'(((d ^ s ^ r) >> 4) & 1);
      end
      2, 3, 7: begin
        cin = (op == 3) ? int'(m_flags[0]) : 0;
        full = d - s - cin; r = full & mask; cf = (full < 0);
        sr = sd - ss - cin; of = (sr > maxp) || (sr < minn);
        af = bit'(((d ^ s ^ r) >> 4) & 1);
        writes = (op != 7);
      end
      4: begin r = d & s; cf = 0; end
      5: begin r = d | s; cf = 0; end
      6: begin r = d ^ s; cf = 0; end
      8: begin r = d & s; cf = 0; writes = 0; end
      9: begin
        r = (d + 1) & mask; sr = sd + 1; of = (sr > maxp);
        af = bit'(((d ^ 1 ^ r) >> 4) & 1);
      end
      10: begin
        r = (d - 1) & mask; sr = sd - 1; of = (sr < minn);
        af = bit'(((d ^ 1 ^ r) >> 4) & 1);
      end
      default: begin known = 0; writes = 0; end
    endcase
    zf = (r == 0);
    sf = bit'((r >> (n-1)) & 1);
    low = r[7:0];
    pf = ~^low;
    if (v && known) m_flags = {of, sf, zf, af, pf, cf};
    exp_we = v && known && writes;
    if (exp_we) m_res = r[15:0];
    @(negedge clk);
    n_checks++;
    if (res_out !== m_res || res_we !== exp_we || flags_out !== m_flags) begin
      n_fail++;
      $display("FAIL %s op=%0d w=%0d: res=%h we=%b flags=%b, expected res=%h we=%b flags=%b",
               tag, op, w, res_out, res_we, flags_out, m_res, exp_we, m_flags);
    end
  endtask

  initial begin
    rst_n = 1'b0; op_valid = 0; op_code = 0; op_word = 0; dst_in = 0; src_in = 0;
    m_flags = '0; m_res = '0;
    repeat (3) @(negedge clk);
    n_checks++;
    if (res_out !== 16'h0 || res_we !== 1'b0 || flags_out !== 6'h0) begin
      n_fail++;
      $display("FAIL R1 in reset: res=%h we=%b flags=%b, expected 0 0 0", res_out, res_we, flags_out);
    end
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    n_checks++;
    if (res_out !== 16'h0 || res_we !== 1'b0 || flags_out !== 6'h0) begin
      n_fail++;
      $display("FAIL R1 after release: res=%h we=%b flags=%b, expected 0 0 0", res_out, res_we, flags_out);
    end

    step(1, 0, 1, 16'h1234, 16'h0F0F, "R2 add word");
    step(1, 2, 1, 16'h0005, 16'h0007, "R2 sub borrow");
    step(1, 0, 1, 16'h7FFF, 16'h0001, "R4 add positive overflow");
    step(1, 0, 1, 16'h8000, 16'h8000, "R4 add negative overflow carry");
    step(1, 0, 0, 16'hAAFF, 16'h5501, "R10 byte add wrap ignores upper");
    step(1, 1, 1, 16'hFFFF, 16'h0000, "R3 adc carry from second stage");
    step(1, 1, 0, 16'h007F, 16'h0000, "R3 R4 adc byte overflow via carry");
    step(1, 0, 1, 16'h0000, 16'h0000, "R8 add zero");
    step(1, 3, 1, 16'h0000, 16'h0000, "R3 sbb no borrow");
    step(1, 2, 1, 16'h0000, 16'h0001, "R2 sub to set CF");
    step(1, 3, 1, 16'h0000, 16'h0000, "R3 sbb borrow from second stage");
    step(1, 2, 1, 16'h8000, 16'h0001, "R5 sub overflow");
    step(1, 3, 0, 16'h0080, 16'h007F, "R5 sbb byte overflow");
    step(1, 7, 1, 16'h0005, 16'h0007, "R9 cmp no write");
    step(1, 8, 1, 16'hFF00, 16'h00FF, "R9 test no write");
    step(1, 2, 1, 16'h0000, 16'h0001, "R6 set CF first");
    step(1, 4, 1, 16'hF0F0, 16'h3C3C, "R6 and clears CF");
    step(1, 2, 1, 16'h0000, 16'h0001, "R6 set CF again");
    step(1, 5, 0, 16'h0012, 16'h0081, "R6 or byte");
    step(1, 6, 1, 16'h8001, 16'h8001, "R6 xor zero");
    step(1, 2, 1, 16'h0000, 16'h0001, "R7 set CF");
    step(1, 9, 0, 16'h007F, 16'h0000, "R7 inc byte overflow keeps CF");
    step(1, 10, 0, 16'h0080, 16'h0000, "R7 dec byte overflow");
    step(1, 10, 1, 16'h8000, 16'h0000, "R7 dec word overflow");
    step(1, 9, 1, 16'hFFFF, 16'h0000, "R7 inc wrap keeps CF");
    step(1, 0, 1, 16'h000F, 16'h0001, "R8 aux carry");
    step(1, 0, 1, 16'h0002, 16'h0001, "R8 parity even");
    step(0, 0, 1, 16'hFFFF, 16'hFFFF, "R11 idle");
    step(1, 13, 1, 16'hFFFF, 16'h0001, "R11 undefined opcode");
    step(1, 15, 0, 16'h0000, 16'h0000, "R11 undefined opcode 15");
    step(1, 0, 1, 16'h0100, 16'h0001, "R12 back to back 1");
    step(1, 0, 1, 16'h0200, 16'h0002, "R12 back to back 2");
    step(0, 0, 1, 0, 0, "R12 pulse ends");
    for (int i = 0; i < 400; i++) begin
      int op;
      op = $urandom_range(0, 12);
      step($urandom_range(0, 7) != 0, op, bit'($urandom_range(0, 1)),
           int'($urandom_range(0, 65535)), int'($urandom_range(0, 65535)), "R2 mixed");
    end
    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule